// File: doc/BRIEF.md
# Macro Result Assignment And Method Emitter

This block sits behind the execute stage of a small macro sequencer. Each accepted operation carries a 32-bit execute result, a destination register index and a 3-bit assignment code. The code decides four things. The first is whether the destination receives the result or the next word from the argument queue. The second is whether the method-address register is reloaded from the result. The third is whether a method word (address, data) goes out on the command output. The fourth is what that word carries. Every emitted word advances the stored address by the stored increment.

The method-address register packs a 12-bit address in bits [11:0] and a 6-bit increment in bits [17:12]. When a code both reloads the register and emits, the word uses the freshly loaded address and increment. The address wraps modulo 4096 after the increment is added.

The operation input, the argument read port and the method output are all valid/ready. An operation is accepted in the cycle when `in_valid` is high and every resource its code needs is present. A fetching code needs `arg_valid`. An emitting code needs `m_ready`. Until then nothing is written, nothing is popped and no state changes. `m_valid` never depends on `m_ready`. `arg_ready` and `in_ready` may depend on `m_ready`. Upstream must hold the operation and argument stable while stalled. All three handshakes complete in the same cycle, so there is no internal buffering.

Top module: `macro_assign_emitter`

## Requirements
- R1: A write aimed at register index 0 is dropped. `rf_we` stays low while the rest of the operation, including fetch, reload and emit, still takes effect.
- R2: Code 0 (fetch only) writes `arg_data` to the destination, pops one argument, discards the result and emits nothing.
- R3: Code 1 (move) writes `in_result` to the destination. It pops nothing and emits nothing.
- R4: Code 2 (move and load method) writes the result and loads address = result[11:0] and increment = result[17:12].
- R5: Code 3 (fetch and emit) writes `arg_data` to the destination, pops one argument, and emits `in_result` as method data.
- R6: Code 4 (move and emit) writes the result and emits the result as method data.
- R7: Code 5 (fetch and load method) writes `arg_data`, pops one argument, and loads the method register from the result.
- R8: Code 6 writes the result, loads the method register from it, pops one argument and emits that argument as data.
- R9: Code 7 writes the result, loads the method register from it, and emits the newly loaded increment, zero-extended, as data.
- R10: `m_addr` is the current address, or the newly loaded one for codes 6 and 7. After each emission the address becomes (address + increment) mod 4096.
- R11: An emitting code with `m_ready` low stalls. `in_ready`, `arg_ready` and `rf_we` stay low, no state changes, and the word is emitted once `m_ready` rises.
- R12: A fetching code with `arg_valid` low stalls. `in_ready`, `rf_we` and `m_valid` stay low, and no state changes.
- R13: After reset the address and increment are 0 and all outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation accepted this cycle |
| in_code | input | 3 | Assignment code 0..7 |
| in_dest | input | 3 | Destination register index |
| in_result | input | 32 | Execute result |
| arg_valid | input | 1 | Argument queue not empty |
| arg_ready | output | 1 | Pop argument this cycle |
| arg_data | input | 32 | Head of argument queue |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| m_valid | output | 1 | Method word present |
| m_ready | input | 1 | Downstream accepts method word |
| m_addr | output | 12 | Method address |
| m_data | output | 32 | Method data |

## Verification
The method-address register is the only state, and it shows at the ports only through `m_addr` on the next emitting operation. A wrong increment, a missed reload or a wrong wrap therefore appears on the first emission after the fault, and that can be many operations later. The bench keeps an arithmetic model of the register and checks `m_addr` on every emission across every code, destination and handshake combination. A wrong stall decision shows in the same cycle as a spurious `rf_we`, `arg_ready` or `m_valid`. It also shows later as an address that advanced when it should not have.

// File: rtl/mae_pkg.sv
package mae_pkg;

  typedef enum logic [2:0] {
    ASG_FETCH_ONLY     = 3'd0,
    ASG_MOVE           = 3'd1,
    ASG_MOVE_LOAD      = 3'd2,
    ASG_FETCH_EMIT     = 3'd3,
    ASG_MOVE_EMIT      = 3'd4,
    ASG_FETCH_LOAD     = 3'd5,
    ASG_LOAD_EMIT_ARG  = 3'd6,
    ASG_LOAD_EMIT_INC  = 3'd7
  } asg_code_e;

  typedef enum logic [1:0] {
    EMIT_RESULT = 2'd0,
    EMIT_ARG    = 2'd1,
    EMIT_INC    = 2'd2
  } emit_src_e;

  typedef struct packed {
    logic      wr_arg;
    logic      fetch;
    logic      load;
    logic      emit;
    emit_src_e src;
  } asg_ctrl_t;

endpackage

// File: rtl/mae_decode.sv
module mae_decode
  import mae_pkg::*;
(
  input  logic [2:0] code,
  output asg_ctrl_t  ctrl
);
  always_comb begin
    ctrl = '{wr_arg: 1'b0, fetch: 1'b0, load: 1'b0, emit: 1'b0, src: EMIT_RESULT};
    unique case (asg_code_e'(code))
      ASG_FETCH_ONLY:    begin ctrl.wr_arg = 1'b1; ctrl.fetch = 1'b1; end
      ASG_MOVE:          ;
      ASG_MOVE_LOAD:     ctrl.load = 1'b1;
      ASG_FETCH_EMIT:    begin ctrl.wr_arg = 1'b1; ctrl.fetch = 1'b1; ctrl.emit = 1'b1; end
      ASG_MOVE_EMIT:     ctrl.emit = 1'b1;
      ASG_FETCH_LOAD:    begin ctrl.wr_arg = 1'b1; ctrl.fetch = 1'b1; ctrl.load = 1'b1; end
      ASG_LOAD_EMIT_ARG: begin
        ctrl.load = 1'b1; ctrl.fetch = 1'b1; ctrl.emit = 1'b1; ctrl.src = EMIT_ARG;
      end
      ASG_LOAD_EMIT_INC: begin
        ctrl.load = 1'b1; ctrl.emit = 1'b1; ctrl.src = EMIT_INC;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mae_method_reg.sv
module mae_method_reg #(
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  localparam int METH_W = ADDR_W + INC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              load,
  input  logic              emit,
  input  logic [METH_W-1:0] load_val,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [INC_W-1:0]  eff_inc
);
  logic [ADDR_W-1:0] addr_q;
  logic [INC_W-1:0]  inc_q;
  logic [ADDR_W-1:0] step;

  // The view used by this operation: freshly loaded value wins.
  always_comb begin
    if (load) begin
      eff_addr = load_val[ADDR_W-1:0];
      eff_inc  = load_val[METH_W-1:ADDR_W];
    end else begin
      eff_addr = addr_q;
      eff_inc  = inc_q;
    end
    step = emit ? {{(ADDR_W-INC_W){1'b0}}, eff_inc} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= '0;
    end else if (commit) begin
      addr_q <= eff_addr + step;   // wraps modulo 2**ADDR_W
      inc_q  <= eff_inc;
    end
  end
endmodule

// File: rtl/macro_assign_emitter.sv
module macro_assign_emitter
  import mae_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 3,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_code,
  input  logic [REG_AW-1:0] in_dest,
  input  logic [DATA_W-1:0] in_result,
  input  logic              arg_valid,
  output logic              arg_ready,
  input  logic [DATA_W-1:0] arg_data,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data
);
  localparam int METH_W = ADDR_W + INC_W;

  asg_ctrl_t         ctrl;
  logic              arg_ok;
  logic              out_ok;
  logic              fire;
  logic [INC_W-1:0]  eff_inc;

  mae_decode u_dec (
    .code (in_code),
    .ctrl (ctrl)
  );

  assign arg_ok = !ctrl.fetch || arg_valid;
  assign out_ok = !ctrl.emit  || m_ready;
  assign fire   = in_valid && arg_ok && out_ok;

  assign in_ready  = fire;
  assign arg_ready = fire && ctrl.fetch;
  assign m_valid   = in_valid && ctrl.emit && arg_ok;

  assign rf_we    = fire && (in_dest != '0);
  assign rf_waddr = in_dest;
  assign rf_wdata = ctrl.wr_arg ? arg_data : in_result;

  mae_method_reg #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_meth (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (fire),
    .load     (ctrl.load),
    .emit     (ctrl.emit),
    .load_val (in_result[METH_W-1:0]),
    .eff_addr (m_addr),
    .eff_inc  (eff_inc)
  );

  always_comb begin
    unique case (ctrl.src)
      EMIT_ARG: m_data = arg_data;
      EMIT_INC: m_data = {{(DATA_W-INC_W){1'b0}}, eff_inc};
      default:  m_data = in_result;
    endcase
  end
endmodule

// File: rtl/mae_checker.sv
module mae_checker #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 3,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_code,
  input logic              arg_valid,
  input logic              arg_ready,
  input logic [DATA_W-1:0] arg_data,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              m_valid,
  input logic              m_ready
);
  logic needs_arg;
  assign needs_arg = (in_code == 3'd0) || (in_code == 3'd3) ||
                     (in_code == 3'd5) || (in_code == 3'd6);

  p_r0_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0));

  p_fetch_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && in_code == 3'd0) |-> (arg_ready && rf_wdata == arg_data));

  p_emit_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |-> (in_valid && in_ready));

  p_out_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> (!in_ready && !rf_we && !arg_ready));

  p_arg_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && needs_arg && !arg_valid) |-> (!in_ready && !rf_we && !m_valid));

  p_accept_needs_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);
endmodule

bind macro_assign_emitter mae_checker #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .ADDR_W(ADDR_W)
) u_mae_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_code(in_code), .arg_valid(arg_valid), .arg_ready(arg_ready),
  .arg_data(arg_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
  .rf_wdata(rf_wdata), .m_valid(m_valid), .m_ready(m_ready)
);

// File: tb/test_macro_assign_emitter.sv
module test_macro_assign_emitter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [2:0]  in_code, in_dest;
  logic [31:0] in_result;
  logic        arg_valid, arg_ready;
  logic [31:0] arg_data;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        m_valid, m_ready;
  logic [11:0] m_addr;
  logic [31:0] m_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [11:0] mdl_addr;
  logic [5:0]  mdl_inc;

  always #10 clk = ~clk;

  macro_assign_emitter i_macro_assign_emitter (
    .clk, .rst_n, .in_valid, .in_ready, .in_code, .in_dest, .in_result,
    .arg_valid, .arg_ready, .arg_data, .rf_we, .rf_waddr, .rf_wdata,
    .m_valid, .m_ready, .m_addr, .m_data
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string code_req(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] c, input logic [2:0] d,
                        input logic [31:0] res, input logic [31:0] arg,
                        input bit av, input bit mr, input string tag);
    bit fetch, load, emit, wr_arg, fire, mv;
    logic [11:0] ea;
    logic [5:0]  ei;
    logic [31:0] ed, ewd;
    string rq;
    fetch  = (c == 0) || (c == 3) || (c == 5) || (c == 6);
    wr_arg = (c == 0) || (c == 3) || (c == 5);
    load   = (c == 2) || (c == 5) || (c == 6) || (c == 7);
    emit   = (c == 3) || (c == 4) || (c == 6) || (c == 7);
    ea = load ? res[11:0] : mdl_addr;
    ei = load ? res[17:12] : mdl_inc;
    ed = (c == 6) ? arg : (c == 7) ? {26'd0, ei} : res;
    ewd = wr_arg ? arg : res;
    mv   = emit && (!fetch || av);
    fire = (!fetch || av) && (!emit || mr);
    rq = (tag != "") ? tag : code_req(c);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; in_dest = d; in_result = res;
    arg_valid = av; arg_data = arg; m_ready = mr;
    #2;
    chk(in_ready == fire, (!av && fetch) ? "R12" : (emit && !mr) ? "R11" : rq,
        "in_ready", {31'd0, in_ready}, {31'd0, fire});
    chk(arg_ready == (fire && fetch), rq, "arg_ready", {31'd0, arg_ready},
        {31'd0, fire && fetch});
    chk(rf_we == (fire && d != 0), (d == 0) ? "R1" : rq, "rf_we",
        {31'd0, rf_we}, {31'd0, fire && d != 0});
    if (fire && d != 0)
      chk(rf_waddr == d && rf_wdata == ewd, rq, "rf_wdata", rf_wdata, ewd);
    chk(m_valid == mv, rq, "m_valid", {31'd0, m_valid}, {31'd0, mv});
    if (mv) begin
      chk(m_addr == ea, "R10", "m_addr", {20'd0, m_addr}, {20'd0, ea});
      chk(m_data == ed, rq, "m_data", m_data, ed);
    end
    @(posedge clk);
    if (fire) begin
      mdl_addr = ea + (emit ? {6'd0, ei} : 12'd0);
      mdl_inc  = ei;
    end
  endtask

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'hA5A3_FFFE;
    pats[1] = 32'h0000_5003;
    pats[2] = 32'h1234_0FF0;
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0; in_dest = '0;
    in_result = '0; arg_valid = 1'b0; arg_data = '0; m_ready = 1'b0;
    mdl_addr = '0; mdl_inc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R13: idle outputs after reset
    chk(!in_ready && !arg_ready && !rf_we && !m_valid, "R13", "idle",
        {28'd0, in_ready, arg_ready, rf_we, m_valid}, 32'd0);
    // R13: first emission uses address 0 and leaves it at 0 (increment 0)
    run_op(3'd4, 3'd1, 32'hDEAD_BEEF, 32'd0, 1'b1, 1'b1, "R13");
    run_op(3'd4, 3'd2, 32'h1111_2222, 32'd0, 1'b1, 1'b1, "R13");
    // R11: stall then release emits the same word once
    run_op(3'd7, 3'd3, 32'h0002_1FFF, 32'd0, 1'b1, 1'b0, "R11");
    run_op(3'd7, 3'd3, 32'h0002_1FFF, 32'd0, 1'b1, 1'b1, "R11");
    run_op(3'd4, 3'd3, 32'h0000_0042, 32'd0, 1'b1, 1'b1, "R10");
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 8; d++)
        for (int p = 0; p < 3; p++)
          for (int h = 0; h < 4; h++)
            run_op(3'(c), 3'(d), pats[p] ^ {8'(c), 8'(d), 16'd0},
                   {16'hC0DE, 4'(c), 4'(d), 4'(p), 4'(h)},
                   h[0], h[1], "");
    // R10: repeated emits wrap the address
    run_op(3'd2, 3'd0, 32'h0003_FF0, 32'd0, 1'b1, 1'b1, "R4");
    for (int k = 0; k < 12; k++)
      run_op(3'd4, 3'd5, 32'(k), 32'd0, 1'b1, 1'b1, "R10");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule